// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the charge in every row of one DRAM bank fresh. It counts clock cycles across a retention window, keeps a pointer to the next row, and asks a command arbiter to open that row and then close it again. Each refresh is two commands, an activate followed by a precharge. Both are offered on one request/grant channel, and the row address travels with the request.

Two policies can be chosen. In spread mode one row is due every `WINDOW_CYC / ROWS` cycles, so the refresh work is evenly spaced over the window. In burst mode every row is due at the first cycle of each window, and the rows are issued back to back. Slots that the arbiter holds off are counted as debt and are never lost. The debt is capped at one full window's worth of rows. A busy flag tells the bank's access logic that a refresh owns the bank.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset `ref_req`, `ref_op` and `bank_busy` are 0 and `ref_row` is 0.
- R2: In spread mode (`burst_mode`=0) a slot falls due at every INTERVAL-th clock edge after reset, where INTERVAL = WINDOW_CYC/ROWS. With nothing pending, the activate request is first visible after clock edge INTERVAL+1 counted from reset release, and after every further INTERVAL edges.
- R3: A refresh is an activate (`ref_op`=2'b01) followed by a precharge (`ref_op`=2'b10) to the same row. `ref_op` is 2'b00 whenever `ref_req` is low.
- R4: The precharge request becomes visible exactly TRAS_CYC edges after the edge at which the activate was granted.
- R5: A request and its op and row stay asserted and unchanged until `ref_gnt` is seen high at a clock edge.
- R6: Slots that fall due while a request waits are kept as debt. Once grants resume, the owed rows are issued back to back.
- R7: The debt never exceeds ROWS. Slots that fall due while the debt is full are dropped.
- R8: The row pointer starts at 0, advances by one at each precharge grant, and wraps from ROWS-1 to 0.
- R9: In burst mode (`burst_mode`=1) the debt is filled to ROWS at the first edge after reset and every WINDOW_CYC edges after that. Row k's activate is visible after edge 2+k*(TRAS_CYC+2) when grants are immediate.
- R10: `bank_busy` is high from the cycle an activate is requested until the last precharge of a run is granted, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 0 = evenly spread refresh, 1 = burst per window |
| ref_req | output | 1 | Refresh command request to the arbiter |
| ref_op | output | 2 | 2'b01 activate, 2'b10 precharge, 2'b00 none |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| ref_gnt | input | 1 | Arbiter accepts the current command at this edge |
| bank_busy | output | 1 | Bank is reserved by refresh |

## Verification
Each command output comes from a register, so a slot counted at edge N shows an activate after edge N+1. A grant at edge G starts the hold, and the precharge request follows after edge G+TRAS_CYC. The bench counts the edges since reset release and drives the grant just after the falling edge. It samples outputs late in the low phase, compares the edge at which each request starts with these figures, and checks the row and op of every granted command against a queue of expected commands.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_PRE  = 2'b10
  } rfsh_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ACT  = 2'b01,
    ST_HOLD = 2'b10,
    ST_PRE  = 2'b11
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int WINDOW_CYC = 8000000,
  parameter int INTERVAL   = 488
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_mode,
  output logic tick_spread,
  output logic tick_burst
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam int IW = $clog2(INTERVAL + 1);

  logic [CW-1:0] win_cnt;
  logic [IW-1:0] ivl_cnt;
  logic          win_end;
  logic          ivl_end;

  assign win_end = (win_cnt == CW'(WINDOW_CYC - 1));
  assign ivl_end = (ivl_cnt == IW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      ivl_cnt <= '0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      ivl_cnt <= ivl_end ? '0 : ivl_cnt + 1'b1;
    end
  end

  assign tick_spread = !burst_mode && ivl_end;
  assign tick_burst  = burst_mode && (win_cnt == '0);

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_cnt < CW'(WINDOW_CYC)); // R9
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
  parameter int ROWS = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_spread,
  input  logic tick_burst,
  input  logic take,
  output logic debt_nz
);
  localparam int DW = $clog2(ROWS + 1);
  localparam logic [DW:0] CAP = (DW+1)'(ROWS);

  logic [DW-1:0] debt;
  logic [DW:0]   after_take;
  logic [DW:0]   summed;
  logic [DW-1:0] debt_nxt;

  always_comb begin
    after_take = {1'b0, debt} - {{DW{1'b0}}, take};
    if (tick_burst)
      summed = after_take + CAP;
    else
      summed = after_take + {{DW{1'b0}}, tick_spread};
    debt_nxt = (summed > CAP) ? CAP[DW-1:0] : summed[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) debt <= '0;
    else     debt <= debt_nxt;
  end

  assign debt_nz = (debt != '0);

  AST_BURST_FILL: assert property (@(posedge clk) disable iff (rst)
    tick_burst |=> debt == CAP[DW-1:0]); // R9
  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (rst)
    (debt == CAP[DW-1:0]) && tick_spread && !take |=> debt == CAP[DW-1:0]); // R7
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROWS     = 16384,
  parameter int TRAS_CYC = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    debt_nz,
  input  logic                    gnt,
  output logic                    take,
  output logic                    req,
  output logic [1:0]              op,
  output logic [$clog2(ROWS)-1:0] row,
  output logic                    busy
);
  localparam int RW = $clog2(ROWS);
  localparam int HW = $clog2(TRAS_CYC + 1);

  rfsh_state_e   state, nxt;
  logic [HW-1:0] hold_cnt;
  logic          pre_done;

  assign pre_done = (state == ST_PRE) && gnt;
  assign take     = (state == ST_ACT) && gnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (debt_nz) nxt = ST_ACT;
      ST_ACT:  if (gnt) nxt = ST_HOLD;
      ST_HOLD: if (hold_cnt == HW'(TRAS_CYC - 1)) nxt = ST_PRE;
      ST_PRE:  if (gnt) nxt = debt_nz ? ST_ACT : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hold_cnt <= '0;
      row      <= '0;
      req      <= 1'b0;
      op       <= OP_NONE;
      busy     <= 1'b0;
    end else begin
      state    <= nxt;
      hold_cnt <= (state == ST_HOLD) ? hold_cnt + 1'b1 : '0;
      if (pre_done) row <= row + 1'b1;
      req  <= (nxt == ST_ACT) || (nxt == ST_PRE);
      busy <= (nxt != ST_IDLE);
      case (nxt)
        ST_ACT:  op <= OP_ACT;
        ST_PRE:  op <= OP_PRE;
        default: op <= OP_NONE;
      endcase
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    pre_done |=> row == $past(row) + RW'(1)); // R8
  AST_ROW_STILL: assert property (@(posedge clk) disable iff (rst)
    !pre_done |=> $stable(row)); // R8
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int WINDOW_CYC = 8000000,
  parameter int ROWS       = 16384,
  parameter int TRAS_CYC   = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    burst_mode,
  output logic                    ref_req,
  output logic [1:0]              ref_op,
  output logic [$clog2(ROWS)-1:0] ref_row,
  input  logic                    ref_gnt,
  output logic                    bank_busy
);
  localparam int INTERVAL = WINDOW_CYC / ROWS;

  logic tick_spread, tick_burst, take, debt_nz;

  rfsh_timer #(.WINDOW_CYC(WINDOW_CYC), .INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .burst_mode(burst_mode),
    .tick_spread(tick_spread), .tick_burst(tick_burst)
  );

  rfsh_debt #(.ROWS(ROWS)) u_debt (
    .clk(clk), .rst(rst), .tick_spread(tick_spread), .tick_burst(tick_burst),
    .take(take), .debt_nz(debt_nz)
  );

  rfsh_seq #(.ROWS(ROWS), .TRAS_CYC(TRAS_CYC)) u_seq (
    .clk(clk), .rst(rst), .debt_nz(debt_nz), .gnt(ref_gnt), .take(take),
    .req(ref_req), .op(ref_op), .row(ref_row), .busy(bank_busy)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ref_req && !ref_gnt |=> ref_req && $stable(ref_op) && $stable(ref_row)); // R5
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ref_req ? $onehot(ref_op) : (ref_op == 2'b00)); // R3
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> bank_busy); // R10
  AST_PRE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ref_req && ref_op == 2'b01 && ref_gnt |=> !ref_req); // R4
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int ROWS = 8;
  localparam int WIN  = 320;
  localparam int TRAS = 3;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic burst_mode = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, bank_busy;
  logic [1:0] ref_op;
  logic [RW-1:0] ref_row;

  int errors = 0, checks = 0, ccount = 0, pre_cnt = 0;
  bit prev_req = 0, prev_gnt = 0;
  int starts[$];
  logic [RW+1:0] exp_q[$];

  always #4 clk = ~clk;

  dram_refresh_sched #(.WINDOW_CYC(WIN), .ROWS(ROWS), .TRAS_CYC(TRAS)) dut (
    .clk(clk), .rst(rst), .burst_mode(burst_mode), .ref_req(ref_req),
    .ref_op(ref_op), .ref_row(ref_row), .ref_gnt(ref_gnt), .bank_busy(bank_busy)
  );

  always @(posedge clk) ccount <= rst ? 0 : ccount + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cc=%0d", tag, act, exp, ccount);
    end
  endtask

  // driver: expected ACT/PRE pairs per row
  task automatic push_rows(input int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({2'b01, RW'(k % ROWS)});
      exp_q.push_back({2'b10, RW'(k % ROWS)});
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (ref_req && (!prev_req || prev_gnt)) starts.push_back(ccount);
      if (ref_req && ref_gnt) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected command", int'(ref_op), 0);
        else begin
          logic [RW+1:0] e;
          e = exp_q.pop_front();
          chk({ref_op, ref_row} == e, "R3 R8 op/row", int'({ref_op, ref_row}), int'(e));
        end
        if (ref_op == 2'b10) pre_cnt++;
      end
      prev_req = ref_req;
      prev_gnt = ref_req && ref_gnt;
    end else begin
      prev_req = 0;
      prev_gnt = 0;
    end
  end

  task automatic wait_cc(input int n);
    do @(negedge clk); while (ccount != n);
    #1;
  endtask

  task automatic start_phase(input bit mode, input bit g, input int rows);
    rst = 1'b1;
    burst_mode = mode;
    ref_gnt = g;
    repeat (3) @(negedge clk);
    #1;
    chk(!ref_req && ref_op == 2'b00 && !bank_busy && ref_row == '0, "R1 reset state",
        int'({ref_req, ref_op, bank_busy, ref_row}), 0);
    exp_q.delete();
    starts.delete();
    pre_cnt = 0;
    push_rows(rows);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // Phase A: spread mode, immediate grants
    start_phase(1'b0, 1'b1, 3);
    wait_cc(43);
    chk(bank_busy == 1'b1, "R10 busy during hold", int'(bank_busy), 1);
    wait_cc(60);
    chk(bank_busy == 1'b0, "R10 idle between slots", int'(bank_busy), 0);
    wait_cc(130);
    chk(starts.size() == 6, "R2 request count", starts.size(), 6);
    if (starts.size() == 6) begin
      chk(starts[0] == 41, "R2 first activate", starts[0], 41);
      chk(starts[1] == 41 + 1 + TRAS, "R4 precharge delay", starts[1], 41 + 1 + TRAS);
      chk(starts[2] == 81, "R2 second slot", starts[2], 81);
      chk(starts[4] == 121, "R2 third slot", starts[4], 121);
    end
    chk(pre_cnt == 3, "R3 refreshes done", pre_cnt, 3);

    // Phase B: grants withheld, debt builds
    start_phase(1'b0, 1'b0, 5);
    wait_cc(205);
    chk(ref_req && ref_op == 2'b01 && ref_row == '0, "R5 request held",
        int'({ref_req, ref_op, ref_row}), int'({1'b1, 2'b01, RW'(0)}));
    wait_cc(210);
    ref_gnt = 1'b1;
    wait_cc(239);
    chk(pre_cnt == 5, "R6 owed rows served", pre_cnt, 5);
    chk(bank_busy == 1'b0, "R10 busy released", int'(bank_busy), 0);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    // Phase C: debt cap and row wrap
    start_phase(1'b0, 1'b0, 9);
    wait_cc(485);
    ref_gnt = 1'b1;
    wait_cc(555);
    chk(pre_cnt == 9, "R7 capped debt", pre_cnt, 9);
    chk(exp_q.size() == 0, "R8 wrap sequence complete", exp_q.size(), 0);

    // Phase D: burst mode
    start_phase(1'b1, 1'b1, 16);
    wait_cc(43);
    chk(pre_cnt == ROWS, "R9 burst rows", pre_cnt, ROWS);
    chk(bank_busy == 1'b0, "R10 busy after burst", int'(bank_busy), 0);
    if (starts.size() >= 3) begin
      chk(starts[0] == 2, "R9 burst first activate", starts[0], 2);
      chk(starts[1] == 2 + 1 + TRAS, "R4 burst precharge", starts[1], 2 + 1 + TRAS);
      chk(starts[2] == 2 + TRAS + 2, "R9 back to back", starts[2], 2 + TRAS + 2);
    end else chk(0, "R9 burst starts", starts.size(), 3);
    wait_cc(321);
    chk(starts.size() == 2 * ROWS, "R9 quiet rest of window", starts.size(), 2 * ROWS);
    wait_cc(370);
    chk(pre_cnt == 2 * ROWS, "R9 second window", pre_cnt, 2 * ROWS);
    if (starts.size() > 2 * ROWS)
      chk(starts[2*ROWS] == WIN + 2, "R9 window restart", starts[2*ROWS], WIN + 2);
    else chk(0, "R9 window restart", starts.size(), 2 * ROWS + 1);
    chk(exp_q.size() == 0, "R8 second pass rows", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule